// File: doc/BRIEF.md
# Bus-Mastering Write DMA Controller

This block copies words from a peripheral's receive buffer into system memory on its own, without the processor touching each word. Software programs a base address and a word count, then pulses `start`. The controller waits until the peripheral reports a buffered word. It then asks the processor for the shared bus with a request/acknowledge pair. It writes to memory only while the acknowledge is held, driving address, data and write strobe the way the processor would.

A mode input sets how the bus is used. In single mode the controller hands the bus back after every word, and the whole request/acknowledge exchange repeats for each word. In burst mode it keeps the bus and writes one word per cycle until the peripheral buffer is empty or the count runs out. At the end of the job it gives a one-cycle `done` pulse. If the processor withdraws the acknowledge in the middle of a transfer, the controller stops driving at once and asks for the bus again before it writes anything more.

Top module: `dma_burst_master`

## Requirements
- R1: After reset, `busReq`, `busDrive`, `memWe`, `perRdEn` and `done` are all 0.
- R2: While a job is armed and `perReady` is 0, `busReq` stays 0. A request is raised only in the cycle after `perReady` was seen high.
- R3: `busDrive` and `memWe` are high only in cycles where `busAck` is 1. No word is written between raising `busReq` and receiving `busAck`.
- R4: Each write puts the current peripheral word (`perData`) on `memData` and pulses `perRdEn` in the same cycle. Write k of a job (counting from 0) goes to address `baseAddr + k`.
- R5: The bus is released in a fixed order. `busDrive` is already 0 in the cycle before `busReq` falls. After `busReq` falls it stays 0 for at least one cycle before it can rise again.
- R6: With `burstMode` = 0 (single mode), at most one word is written per request/acknowledge exchange. A job of N words therefore raises `busReq` N times.
- R7: With `burstMode` = 1 (burst mode), words are written in consecutive cycles under one grant for as long as `perReady` stays 1. When the buffer empties, the controller releases the bus and requests it again when data returns.
- R8: A job writes exactly `xferLen` words and then pulses `done` for one cycle. Words still in the peripheral are not read afterwards.
- R9: If `busAck` falls while the controller is transferring, `busDrive` and `memWe` go to 0 in that same cycle. The controller drops `busReq` and raises it again before the next write. No word is lost or duplicated.
- R10: A `start` pulse while a job is active is ignored. A job with `xferLen` = 0 gives a `done` pulse without ever requesting the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: latch base and length and arm a job (ignored while busy) |
| baseAddr | input | AW | First memory word address of the job |
| xferLen | input | LW | Number of words to move |
| burstMode | input | 1 | 1 = hold bus until buffer empty, 0 = one word per grant |
| perReady | input | 1 | Peripheral buffer holds at least one word |
| perData | input | DW | Head word of the peripheral buffer |
| perRdEn | output | 1 | Pops the head word of the peripheral buffer |
| busReq | output | 1 | Bus request to the processor |
| busAck | input | 1 | Bus acknowledge from the processor |
| busDrive | output | 1 | Drive enable for the memory bus outputs |
| memAddr | output | AW | Memory write address (0 when not driving) |
| memData | output | DW | Memory write data (0 when not driving) |
| memWe | output | 1 | Memory write strobe |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench uses a 12-bit address, 16-bit data and a 4-bit length. That keeps jobs short while still allowing multi-word bursts, a zero-length job and leftover buffer words after the count is used up. A processor model with a settable acknowledge delay and a one-shot withdrawal of the acknowledge, triggered after a chosen write, brings the mid-burst abort and the re-request path within reach. Pre-filled and late-filled peripheral queues exercise both the hold-until-empty behaviour and the wait for the first ready word.

// File: rtl/dma_burst_master_pkg.sv
package dma_burst_master_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_REL,
    ST_GAP
  } dmaState_e;

  typedef struct packed {
    logic load;
    logic write;
  } dpStrobe_t;

endpackage

// File: rtl/dma_burst_master_dpath.sv
module dma_burst_master_dpath
  import dma_burst_master_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic          drive,
  input  logic [AW-1:0] baseAddr,
  input  logic [LW-1:0] xferLen,
  input  logic [DW-1:0] perData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          remZero,
  output logic          remOne
);

  localparam logic [LW-1:0] LEN_ONE  = LW'(1);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  logic [AW-1:0] addrQ;
  logic [LW-1:0] remQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      remQ  <= '0;
    end else if (strb.load) begin
      addrQ <= baseAddr;
      remQ  <= xferLen;
    end else if (strb.write) begin
      addrQ <= addrQ + ADDR_ONE;
      remQ  <= remQ - LEN_ONE;
    end
  end

  assign remZero = (remQ == '0);
  assign remOne  = (remQ == LEN_ONE);

  // bus outputs modelled as released (zero) whenever not driven
  assign memAddr = drive ? addrQ   : '0;
  assign memData = drive ? perData : '0;

endmodule

// File: rtl/dma_burst_master_ctrl.sv
module dma_burst_master_ctrl
  import dma_burst_master_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      burstMode,
  input  logic      perReady,
  input  logic      busAck,
  input  logic      remZero,
  input  logic      remOne,
  output dpStrobe_t strb,
  output logic      busReq,
  output logic      busDrive,
  output logic      done
);

  dmaState_e st, nxt;
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      st    <= nxt;
      doneQ <= (st == ST_WAIT) && remZero;
    end
  end

  always_comb begin
    nxt      = st;
    strb     = '0;
    busReq   = 1'b0;
    busDrive = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nxt       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (remZero)       nxt = ST_IDLE;
        else if (perReady) nxt = ST_REQ;
      end
      ST_REQ: begin
        busReq = 1'b1;
        if (busAck) nxt = ST_XFER;
      end
      ST_XFER: begin
        busReq = 1'b1;
        if (!busAck) begin
          nxt = ST_GAP;                 // grant withdrawn: release at once
        end else begin
          busDrive = 1'b1;
          if (perReady && !remZero) begin
            strb.write = 1'b1;
            if (!burstMode || remOne) nxt = ST_REL;
          end else begin
            nxt = ST_REL;               // buffer drained
          end
        end
      end
      ST_REL: begin
        busReq = 1'b1;                  // bus already released, request held one cycle
        nxt    = ST_GAP;
      end
      ST_GAP: begin
        if (!busAck) nxt = ST_WAIT;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign done = doneQ;

endmodule

// File: rtl/dma_burst_master.sv
module dma_burst_master
  import dma_burst_master_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] baseAddr,
  input  logic [LW-1:0] xferLen,
  input  logic          burstMode,
  input  logic          perReady,
  input  logic [DW-1:0] perData,
  output logic          perRdEn,
  output logic          busReq,
  input  logic          busAck,
  output logic          busDrive,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          memWe,
  output logic          done
);

  dpStrobe_t strb;
  logic remZero, remOne;

  dma_burst_master_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .burstMode(burstMode),
    .perReady (perReady),
    .busAck   (busAck),
    .remZero  (remZero),
    .remOne   (remOne),
    .strb     (strb),
    .busReq   (busReq),
    .busDrive (busDrive),
    .done     (done)
  );

  dma_burst_master_dpath #(.AW(AW), .DW(DW), .LW(LW)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .drive   (busDrive),
    .baseAddr(baseAddr),
    .xferLen (xferLen),
    .perData (perData),
    .memAddr (memAddr),
    .memData (memData),
    .remZero (remZero),
    .remOne  (remOne)
  );

  assign memWe   = strb.write;
  assign perRdEn = strb.write;

endmodule

// File: rtl/dma_burst_master_chk.sv
module dma_burst_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busReq,
  input logic          busAck,
  input logic          busDrive,
  input logic          memWe,
  input logic          perReady,
  input logic          burstMode,
  input logic          done,
  input logic [AW-1:0] memAddr
);

  // R3
  drive_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (busAck && busReq));

  // R3
  write_needs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busDrive);

  // R2
  req_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(perReady));

  // R5
  release_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> !$past(busDrive));

  // R5
  req_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |=> !busReq);

  // R6
  single_one_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !burstMode) |=> !memWe);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + AW'(1)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busReq && !busDrive));

endmodule

bind dma_burst_master dma_burst_master_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busAck   (busAck),
  .busDrive (busDrive),
  .memWe    (memWe),
  .perReady (perReady),
  .burstMode(burstMode),
  .done     (done),
  .memAddr  (memAddr)
);

// File: tb/tb_dma_burst_master.sv
module tb_dma_burst_master;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [LW-1:0] xferLen = '0;
  logic          burstMode = 1'b0;
  logic          perReady = 1'b0;
  logic [DW-1:0] perData = '0;
  logic          perRdEn;
  logic          busReq;
  logic          busAck = 1'b0;
  logic          busDrive;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          memWe;
  logic          done;

  dma_burst_master #(.AW(AW), .DW(DW), .LW(LW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .xferLen(xferLen), .burstMode(burstMode), .perReady(perReady),
    .perData(perData), .perRdEn(perRdEn), .busReq(busReq), .busAck(busAck),
    .busDrive(busDrive), .memAddr(memAddr), .memData(memData),
    .memWe(memWe), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [DW-1:0] fifo[$];
  bit   popPending = 0;
  int   cyc = 0;
  int   ackDelay = 1;
  int   ackCnt = 0;
  bit   holdOff = 0;
  int   abortAtWrite = -1;
  int   abortCyc = -1;
  int   expAddr = 0;
  int   expRem = 0;
  int   writesJob = 0;
  int   writesGrant = 0;
  int   reqRises = 0;
  int   doneCnt = 0;
  int   lowRun = 100;
  int   lastWriteCyc = -10;
  bit   lastReq = 0;
  bit   lastDrive = 0;
  bit   monOn = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // processor model, peripheral queue and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (popPending) begin
      void'(fifo.pop_front());
      popPending = 0;
    end
    if (abortAtWrite >= 0 && writesJob == abortAtWrite && busAck && busReq) begin
      busAck = 0;
      holdOff = 1;
      abortAtWrite = -1;
      abortCyc = cyc;
    end else if (!busReq) begin
      busAck = 0;
      holdOff = 0;
      ackCnt = 0;
    end else if (!busAck && !holdOff) begin
      ackCnt++;
      if (ackCnt >= ackDelay) busAck = 1;
    end
    perReady = (fifo.size() > 0);
    perData  = perReady ? fifo[0] : '0;
    #1;
    if (monOn) begin
      if (busDrive || memWe) chk(busAck, "R3 drive/write without ack", busAck, 1);
      if (cyc == abortCyc) begin
        chk(!busDrive, "R9 drive after ack drop", busDrive, 0);
        chk(!memWe, "R9 write after ack drop", memWe, 0);
      end
      if (busReq && !lastReq) begin
        reqRises++;
        chk(lowRun >= 1, "R5 request low gap", lowRun, 1);
        writesGrant = 0;
      end
      if (lastReq && !busReq) chk(!lastDrive, "R5 drive off before request drop", lastDrive, 0);
      if (memWe) begin
        chk(memAddr == AW'(expAddr), "R4 address", memAddr, AW'(expAddr));
        chk(memData == perData, "R4 data", memData, perData);
        chk(perRdEn, "R4 pop with write", perRdEn, 1);
        chk(expRem > 0, "R8 write beyond length", expRem, 1);
        if (!burstMode) chk(writesGrant == 0, "R6 one word per grant", writesGrant + 1, 1);
        else if (writesGrant > 0) chk(cyc == lastWriteCyc + 1, "R7 consecutive burst writes", cyc, lastWriteCyc + 1);
        writesGrant++;
        lastWriteCyc = cyc;
        expAddr++;
        expRem--;
        writesJob++;
        popPending = 1;
      end
      if (done) doneCnt++;
      if (!busReq) lowRun++; else lowRun = 0;
    end
    lastReq = busReq;
    lastDrive = busDrive;
  end

  task automatic newJob(input int base, input int len, input bit burst);
    @(negedge clk); #3;
    expAddr = base; expRem = len; writesJob = 0; reqRises = 0; doneCnt = 0;
    baseAddr = AW'(base); xferLen = LW'(len); burstMode = burst;
    start = 1;
    @(negedge clk); #3;
    start = 0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (doneCnt == 0 && n < 300) begin
      @(negedge clk); n++;
    end
    chk(doneCnt == 1, tag, doneCnt, 1);
    repeat (2) @(negedge clk);
    #3;
  endtask

  task automatic pushWords(input int n, input int seed);
    for (int i = 0; i < n; i++) fifo.push_back(DW'(seed * 37 + i * 113 + 5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!busReq && !busDrive && !memWe && !perRdEn && !done, "R1 reset outputs",
        {busReq, busDrive, memWe, perRdEn, done}, 0);
    rstN = 1;
    monOn = 1;
    @(negedge clk); #3;
    chk(!busReq && !done, "R1 idle after reset", {busReq, done}, 0);

    // zero-length job
    newJob(12, 0, 0);
    waitDone("R10 zero-length done");
    chk(reqRises == 0, "R10 zero-length no request", reqRises, 0);

    // armed with empty buffer, then late data, single mode
    ackDelay = 2;
    newJob('h100, 2, 0);
    repeat (8) @(negedge clk);
    #3;
    chk(reqRises == 0, "R2 no request without data", reqRises, 0);
    pushWords(2, 1);
    waitDone("R8 done after late data");
    chk(writesJob == 2, "R8 word count", writesJob, 2);
    chk(reqRises == 2, "R6 grants in single mode", reqRises, 2);

    // single mode with extra buffered words
    ackDelay = 3;
    pushWords(5, 2);
    newJob('h3f0, 3, 0);
    waitDone("R8 single job done");
    chk(writesJob == 3, "R8 single word count", writesJob, 3);
    chk(reqRises == 3, "R6 request per word", reqRises, 3);
    repeat (5) @(negedge clk);
    #3;
    chk(fifo.size() == 2, "R8 leftover words untouched", fifo.size(), 2);
    chk(!busReq, "R8 no request after done", busReq, 0);
    fifo.delete();

    // burst, full buffer, restart attempt mid-job ignored
    ackDelay = 1;
    pushWords(4, 3);
    newJob('h7fe, 4, 1);
    repeat (2) @(negedge clk);
    #3;
    baseAddr = 'h555; start = 1;
    @(negedge clk); #3;
    start = 0;
    waitDone("R10 done despite restart pulse");
    chk(writesJob == 4, "R7 burst word count", writesJob, 4);
    chk(reqRises == 1, "R7 single grant for burst", reqRises, 1);

    // burst drains buffer, releases, resumes
    pushWords(3, 4);
    newJob('h020, 6, 1);
    repeat (15) @(negedge clk);
    #3;
    chk(writesJob == 3, "R7 written before drain", writesJob, 3);
    chk(!busReq, "R7 bus released when empty", busReq, 0);
    pushWords(3, 5);
    waitDone("R7 resumed burst done");
    chk(writesJob == 6, "R7 total words", writesJob, 6);
    chk(reqRises == 2, "R7 second grant", reqRises, 2);

    // acknowledge withdrawn mid-burst
    ackDelay = 2;
    pushWords(5, 6);
    abortAtWrite = 2;
    newJob('h200, 5, 1);
    waitDone("R9 job completes after abort");
    chk(abortCyc > 0, "R9 abort happened", abortCyc > 0, 1);
    chk(writesJob == 5, "R9 no word lost", writesJob, 5);
    chk(reqRises == 2, "R9 re-request", reqRises, 2);
    chk(fifo.size() == 0, "R9 no word duplicated", fifo.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule